// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM that sits on a three-wire slave link: a chip-select `cs`, a shift clock `sk` and a serial input `di`, with one serial output. It stores 256 words of 16 bits in ordinary flops. All logic runs on a fast system clock `clk`. The link inputs are taken to be already synchronised to that clock. A rising edge of `sk` is found by comparing `sk` with its value one `clk` earlier. Rises and falls of `cs` are found the same way.

A command is a frame with a start bit, an operation code and a word address. Five commands exist: read a word, write a word, write every word, allow writes, and forbid writes. A write only takes effect when the chip-select is released on the right bit count. After a write the device is busy for a fixed number of system clocks, and it reports that state on its output if it is selected. The output pin is modelled as a data bit `do_bit` with an enable `do_en`. A pad outside the block turns this pair into a three-state driver.

Top module: `tri_wire_eeprom`

## Requirements
- R1: After reset, `do_en` is 0, writes are forbidden and every word of the array reads as 0000h.
- R2: A frame begins at the first `sk` rise with `cs` high and `di` = 1; zeros before it are ignored. The frame continues with a 2-bit opcode and then ADDR_W address bits, most significant bit first. The opcodes are read = 10 and write = 01. Opcode 00 takes the top two address bits as a sub-code: 11 allows writes, 00 forbids them, 01 writes all words. Opcode 11 and sub-code 10 are ignored.
- R3: For a read, `do_en` = 1 and `do_bit` = 0 after the last address bit (the 11th `sk` rise of the frame). The `sk` rises 12 to 27 then present D15 down to D0 on `do_bit`.
- R4: Lowering `cs` in the middle of a read ends it, and `do_en` goes to 0.
- R5: `do_en` is 0 while `cs` is low, and also while selected with no read data or status to show.
- R6: A write or write-all takes effect on the `cs` fall, but only when exactly 27 `sk` rises have been counted, the start bit included. The data bits are D15 first down to D0.
- R7: If `cs` falls after fewer or more than 27 rises, the command is dropped: nothing is written and no busy period starts.
- R8: While writes are forbidden, write and write-all commands change nothing and start no busy period.
- R9: Write-all puts its data word into every address.
- R10: Each write that takes effect starts a busy period of BUSY_CYC `clk` cycles. If `cs` is raised during that period, `do_en` = 1 and `do_bit` reads 0 while busy and 1 once ready. This lasts until `cs` falls.
- R11: No command is decoded in a selection that started while busy, even after the busy period has ended.
- R12: After a frame is complete, later `sk` rises in the same selection are ignored and do not start a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, synchronous to clk |
| sk | input | 1 | Serial shift clock, sampled by clk |
| di | input | 1 | Serial data in, taken on sk rises |
| do_bit | output | 1 | Serial data out value |
| do_en | output | 1 | Output drive enable (0 = high impedance) |

## Verification
The assertions rely on `cs`, `sk` and `di` being synchronous to `clk` and stable for at least one `clk` between changes. This ensures each `sk` rise and each `cs` edge is seen exactly once. They also rely on BUSY_CYC being larger than one. The stimulus meets this by changing link inputs only on falling `clk` edges and holding each `sk` level for two `clk` cycles. It also keeps `cs` fixed for at least two cycles around every select and release.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_RDATA, ST_WDATA, ST_DONE, ST_STATUS
  } fsm_state_t;

  typedef enum logic [2:0] {
    CMD_READ, CMD_WRITE, CMD_WRALL, CMD_WEN, CMD_WDIS, CMD_NONE
  } cmd_kind_t;

  // sk rises up to and including the last address bit
  function automatic int header_clocks(input int addr_w);
    return 1 + 2 + addr_w;
  endfunction

  // sk rises up to and including the last data bit of a write frame
  function automatic int frame_clocks(input int addr_w, input int data_w);
    return header_clocks(addr_w) + data_w;
  endfunction

  function automatic cmd_kind_t decode_cmd(input logic [1:0] op, input logic [1:0] sub);
    cmd_kind_t k;
    k = CMD_NONE;
    case (op)
      2'b10: k = CMD_READ;
      2'b01: k = CMD_WRITE;
      2'b00: begin
        case (sub)
          2'b11:   k = CMD_WEN;
          2'b00:   k = CMD_WDIS;
          2'b01:   k = CMD_WRALL;
          default: k = CMD_NONE;
        endcase
      end
      default: k = CMD_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/tw_edge_detect.sv
module tw_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic cs_rise,
  output logic cs_fall,
  output logic sk_rise
);
  logic cs_q, sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
    end
  end

  assign cs_rise = cs & ~cs_q;
  assign cs_fall = ~cs & cs_q;
  assign sk_rise = cs & sk & ~sk_q;
endmodule

// File: rtl/tw_word_store.sv
module tw_word_store #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              commit_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(BUSY_CYC + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BW-1:0]     busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++)
        if (commit_all || (wr_addr == ADDR_W'(i))) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy_cnt <= '0;
    else if (commit)          busy_cnt <= BW'(BUSY_CYC);
    else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy    = (busy_cnt != '0);
  assign rd_word = mem[rd_addr];

  // a commit can only come from a frame decoded while idle
  assert_commit_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
  // the stored word is visible on the next cycle
  assert_word_landed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !commit_all && rd_addr == wr_addr) |=> (rd_word == $past(wr_data)));
endmodule

// File: rtl/tw_cmd_fsm.sv
module tw_cmd_fsm
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              sk_rise,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_start,
  output logic              commit,
  output logic              commit_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              do_bit,
  output logic              do_en
);
  localparam int HDR_CLK   = header_clocks(ADDR_W);
  localparam int FRAME_CLK = frame_clocks(ADDR_W, DATA_W);
  localparam int CNT_W     = $clog2(FRAME_CLK + 2);
  localparam int SH_W      = 2 + ADDR_W;

  fsm_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q, sh_nx;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              first_q, wen_q, all_q;
  cmd_kind_t         kind_nx;
  logic              hdr_done;

  assign sh_nx    = {sh_q[SH_W-2:0], di};
  assign kind_nx  = decode_cmd(sh_nx[SH_W-1 -: 2], sh_nx[ADDR_W-1 -: 2]);
  assign hdr_done = sk_rise && (state_q == ST_CMD) && (cnt_q == CNT_W'(HDR_CLK - 1));
  assign rd_start = hdr_done && (kind_nx == CMD_READ);

  assign rd_addr    = sh_q[ADDR_W-1:0];
  assign wr_addr    = sh_q[ADDR_W-1:0];
  assign wr_data    = wd_q;
  assign commit_all = all_q;
  assign commit     = cs_fall && (state_q == ST_WDATA) &&
                      (cnt_q == CNT_W'(FRAME_CLK)) && wen_q;

  assign do_en  = (state_q == ST_RDATA) || (state_q == ST_STATUS);
  assign do_bit = (state_q == ST_STATUS) ? !busy : (first_q ? 1'b0 : rd_q[DATA_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      first_q <= 1'b0;
      wen_q   <= 1'b0;
      all_q   <= 1'b0;
    end else if (!cs) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else if (cs_rise) begin
      state_q <= busy ? ST_STATUS : ST_IDLE;
      cnt_q   <= '0;
    end else if (sk_rise) begin
      case (state_q)
        ST_IDLE: if (di) begin
          state_q <= ST_CMD;
          cnt_q   <= CNT_W'(1);
        end
        ST_CMD: begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_CLK - 1)) begin
            case (kind_nx)
              CMD_READ:  begin state_q <= ST_RDATA; first_q <= 1'b1; end
              CMD_WRITE: begin state_q <= ST_WDATA; all_q <= 1'b0; end
              CMD_WRALL: begin state_q <= ST_WDATA; all_q <= 1'b1; end
              CMD_WEN:   begin state_q <= ST_DONE;  wen_q <= 1'b1; end
              CMD_WDIS:  begin state_q <= ST_DONE;  wen_q <= 1'b0; end
              default:   state_q <= ST_DONE;
            endcase
          end
        end
        ST_RDATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(FRAME_CLK)) begin
            state_q <= ST_DONE;
          end else if (first_q) begin
            first_q <= 1'b0;
            rd_q    <= rd_word;
          end else begin
            rd_q <= rd_q << 1;
          end
        end
        ST_WDATA: begin
          wd_q <= {wd_q[DATA_W-2:0], di};
          if (cnt_q <= CNT_W'(FRAME_CLK)) cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // the cycle after the header of a read, the dummy zero is on the pin
  assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (do_en && !do_bit));
  // output released while deselected
  assert_hiz_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !$past(cs)) |-> !do_en);
  // a write only ever lands on a release of the select line
  assert_commit_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!cs && $past(cs)));
endmodule

// File: rtl/tri_wire_eeprom.sv
module tri_wire_eeprom #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_bit,
  output logic do_en
);
  logic              cs_rise, cs_fall, sk_rise;
  logic              busy, commit, commit_all, rd_start;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_word, wr_data;

  tw_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .sk_rise(sk_rise)
  );

  tw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di),
    .sk_rise(sk_rise), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr), .rd_start(rd_start),
    .commit(commit), .commit_all(commit_all), .wr_addr(wr_addr),
    .wr_data(wr_data), .do_bit(do_bit), .do_en(do_en)
  );

  tw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_all(commit_all),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_word(rd_word), .busy(busy)
  );

  // selecting during the busy period shows status on the pin
  assert_status_shown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && busy) |=> do_en);
  // the decoder starts no read while the store is busy
  assert_no_read_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_start);
  // commit and read start are distinct frame outcomes
  assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, rd_start}));
endmodule

// File: tb/tri_wire_eeprom_tb_top.sv
module tri_wire_eeprom_tb_top;
  logic clk = 1'b0;
  logic rst_n, cs, sk, di;
  logic do_bit, do_en;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  bit   model_we = 1'b0;
  logic [15:0] model_mem [256];

  always #2.5 clk = ~clk;

  tri_wire_eeprom dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_bit(do_bit), .do_en(do_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b; sk = 1'b0; tick(2);
    sk = 1'b1; tick(2);
  endtask

  task automatic cs_up();
    cs = 1'b1; sk = 1'b0; di = 1'b0; tick(2);
  endtask

  task automatic cs_down();
    cs = 1'b0; sk = 1'b0; di = 1'b0; tick(2);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [7:0] a);
    sk_bit(1'b1);
    sk_bit(op[1]); sk_bit(op[0]);
    for (int i = 7; i >= 0; i--) sk_bit(a[i]);
  endtask

  // data clocks beyond 16 send zeros; the model commits only at exactly 16
  task automatic write_frame(input logic [1:0] op, input logic [7:0] a,
                             input logic [15:0] d, input int ndata);
    cs_up();
    send_hdr(op, a);
    for (int k = 0; k < ndata; k++) sk_bit(k < 16 ? d[15-k] : 1'b0);
    cs_down();
    if (ndata == 16 && model_we) begin
      if (op == 2'b01) model_mem[a] = d;
      else if (op == 2'b00 && a[7:6] == 2'b01)
        for (int i = 0; i < 256; i++) model_mem[i] = d;
    end
  endtask

  task automatic special(input logic [1:0] sub);
    cs_up();
    send_hdr(2'b00, {sub, 6'h15});
    cs_down();
    if (sub == 2'b11) model_we = 1'b1;
    if (sub == 2'b00) model_we = 1'b0;
  endtask

  task automatic read_check(input logic [7:0] a, input int nlead, input string req);
    logic [15:0] got;
    cs_up();
    for (int i = 0; i < nlead; i++) sk_bit(1'b0);
    send_hdr(2'b10, a);
    chk(do_en && !do_bit, req, "dummy bit", {30'd0, do_en, do_bit}, 32'h2);
    got = '0;
    for (int k = 15; k >= 0; k--) begin
      sk_bit(1'b0);
      got[k] = do_en ? do_bit : 1'bx;
    end
    chk(got === model_mem[a], req, "read word", {16'd0, got}, {16'd0, model_mem[a]});
    cs_down();
  endtask

  task automatic no_busy_check(input string req);
    cs_up();
    chk(!do_en, req, "no busy status", {31'd0, do_en}, 32'h0);
    cs_down();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model_mem[i] = 16'h0000;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk(!do_en, "R1", "do_en after reset", {31'd0, do_en}, 32'h0);
    cs_up();
    chk(!do_en, "R5", "idle selected drive", {31'd0, do_en}, 32'h0);
    cs_down();
    read_check(8'h5A, 0, "R1");

    // writes forbidden out of reset
    write_frame(2'b01, 8'h5A, 16'hBEEF, 16);
    no_busy_check("R8");
    read_check(8'h5A, 0, "R8");

    // enable, write, then watch status through the busy period
    special(2'b11);
    write_frame(2'b01, 8'h5A, 16'hBEEF, 16);
    cs_up();
    chk(do_en && !do_bit, "R10", "status busy early", {30'd0, do_en, do_bit}, 32'h2);
    tick(50);
    chk(do_en && !do_bit, "R10", "status busy late", {30'd0, do_en, do_bit}, 32'h2);
    send_hdr(2'b10, 8'h5A);
    chk(do_en && do_bit, "R11", "status ready, header ignored", {30'd0, do_en, do_bit}, 32'h3);
    sk_bit(1'b0); sk_bit(1'b1);
    chk(do_en && do_bit, "R11", "status held", {30'd0, do_en, do_bit}, 32'h3);
    cs_down();
    chk(!do_en, "R5", "release after status", {31'd0, do_en}, 32'h0);
    read_check(8'h5A, 0, "R6");

    // second word, distinct pattern
    write_frame(2'b01, 8'hC3, 16'h8001, 16);
    tick(80);
    read_check(8'hC3, 0, "R6");
    read_check(8'h5A, 2, "R2");

    // wrong bit counts abort
    write_frame(2'b01, 8'h33, 16'h1111, 15);
    no_busy_check("R7");
    read_check(8'h33, 0, "R7");
    write_frame(2'b01, 8'h33, 16'h2222, 17);
    no_busy_check("R7");
    read_check(8'h33, 0, "R7");

    // read cancelled midway
    cs_up();
    send_hdr(2'b10, 8'h5A);
    sk_bit(1'b0); sk_bit(1'b0); sk_bit(1'b0);
    chk(do_en, "R4", "drive during read", {31'd0, do_en}, 32'h1);
    cs = 1'b0; tick(2);
    chk(!do_en, "R4", "read cancelled", {31'd0, do_en}, 32'h0);
    cs_down();
    read_check(8'h5A, 0, "R4");

    // unassigned opcode ignored
    write_frame(2'b11, 8'h5A, 16'h0F0F, 16);
    no_busy_check("R2");
    read_check(8'h5A, 0, "R2");

    // write-all
    write_frame(2'b00, 8'h40, 16'h1234, 16);
    tick(80);
    read_check(8'h00, 0, "R9");
    read_check(8'hFF, 0, "R9");
    read_check(8'h5A, 0, "R9");

    // bits after a complete read are ignored
    cs_up();
    send_hdr(2'b10, 8'h10);
    for (int k = 0; k < 16; k++) sk_bit(1'b0);
    sk_bit(1'b0);
    chk(!do_en, "R12", "after read end", {31'd0, do_en}, 32'h0);
    send_hdr(2'b10, 8'h10);
    chk(!do_en, "R12", "second header ignored", {31'd0, do_en}, 32'h0);
    cs_down();

    // disable then write ignored
    special(2'b00);
    write_frame(2'b01, 8'h5A, 16'h0000, 16);
    no_busy_check("R8");
    read_check(8'h5A, 0, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule